// File: doc/BRIEF.md
# Interrupt Distributor with 16-bit CPU Target Masks

This block collects interrupt lines from devices and from software and routes each one to a set of CPU interfaces. Each source that is enabled, pending and not already being serviced is presented to every CPU interface named in its target mask. The result is one registered pending vector per CPU interface. Software programs the block through a simple word-addressed register bus. Each access carries the index of the CPU making it, so the private sources can be banked per CPU.

Sources 0 to 15 are software interrupts, raised by a write to a dedicated register. Sources 16 to 31 are private peripheral lines, one set per CPU. Sources 32 and up are shared device lines. Every shared source has a 16-bit target mask, and two masks share one 32-bit word. The CPU interface side acknowledges a source, which marks it active, and later ends it, which clears the active mark. The number of sources follows from a type code parameter.

Top module: `idist_top`

## Requirements
- R1: A write to the enable-set bank (0x100 + (id/32)*4) sets the enable of every source whose bit (id mod 32) is 1. A write to the enable-clear bank (0x180 + (id/32)*4) clears those enables. Zero bits change nothing. Both banks read back the current enables.
- R2: The target mask of shared source id sits in the word at 0x800 + ((id*2) & ~3). Even ids use bits 15:0 and odd ids use bits 31:16. The word reads back what was written.
- R3: Target words for sources 0 to 31 (0x800 to 0x83C) read as the one-hot mask (1 << bus_cpu) in both halves. Writes to these words are ignored.
- R4: Enables, pending state and active state of sources 0 to 31 are held separately for each CPU interface. An access or event from one CPU leaves the others unchanged.
- R5: The trigger words at 0xC00 + (id/32)*4 hold one bit per source: 1 is rising edge, 0 is level high. Bits for sources 0 to 15 always read 1 and ignore writes.
- R6: The type register at 0x004 returns the parameter code N in bits 4:0. The source count is min((N+1)*32, 510).
- R7: A write to 0xF00 takes the source id from bits 3:0 and a CPU map from bits 23:8, and ignores bits 7:4. That id becomes pending on every CPU whose map bit is 1.
- R8: Bit 0 of the control register at 0x000 resets to 0. While it is 0, every bit of cpu_pend is 0.
- R9: An edge-triggered source latches pending on a rising input and holds it until acknowledged. A level source is pending exactly while its input is high.
- R10: cpu_pend bit k*NUM_SRC+id is 1 exactly when the source is enabled, pending and not active, and CPU k is its target. The bit follows one clock after its causes. An acknowledge marks the source active, and an end-of-interrupt clears the active mark.
- R11: When a software interrupt sets a source pending in the same cycle as that source is acknowledged, the new pending state survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data returns on the next cycle |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_rdata | output | 32 | Registered read data |
| ppi_lines | input | NUM_CPU*16 | Private lines, sources 16..31, 16 per CPU |
| spi_lines | input | NUM_SRC-32 | Shared device lines, sources 32 and up |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | CPU giving the acknowledge |
| ack_id | input | ID_W | Source being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | CPU_W | CPU ending the interrupt |
| eoi_id | input | ID_W | Source being ended |
| cpu_pend | output | NUM_CPU*NUM_SRC | Forwarded pending vector, NUM_SRC bits per CPU |

## Verification
Two events can land on the same private source in one cycle. A software-interrupt write can set it pending while the CPU interface acknowledges it. The bench provokes this by asserting the acknowledge in exactly the cycle that the register write reaches the CPU bank. It then judges the outcome in two steps. The source must first be hidden because it is active. After an end-of-interrupt it must come back, which shows that the pending state written in that cycle was kept.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam int TGT_W    = 16;
  localparam int PRIV_N   = 32;
  localparam int SGI_N    = 16;
  localparam int SRC_CAP  = 510;
  localparam int A_CTRL   = 'h000;
  localparam int A_TYPE   = 'h004;
  localparam int A_ENSET  = 'h100;
  localparam int A_ENCLR  = 'h180;
  localparam int A_TGT    = 'h800;
  localparam int A_TRIG   = 'hC00;
  localparam int A_SWINT  = 'hF00;

  function automatic int src_count(int code);
    return ((code + 1) * 32 > SRC_CAP) ? SRC_CAP : (code + 1) * 32;
  endfunction
endpackage

// File: rtl/idist_src_state.sv
module idist_src_state #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_in,
  input  logic [N-1:0] edge_cfg,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] eoi,
  output logic [N-1:0] pend,
  output logic [N-1:0] act
);
  logic [N-1:0] lvl_q, lat_q, act_q, rise;

  assign rise = lvl_in & ~lvl_q & edge_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      lat_q <= '0;
      act_q <= '0;
    end else begin
      lvl_q <= lvl_in;
      // new set requests win over a same-cycle acknowledge
      lat_q <= (lat_q & ~ack) | rise | sw_set;
      act_q <= (act_q & ~eoi) | ack;
    end
  end

  assign pend = (edge_cfg & lat_q) | (~edge_cfg & lvl_in);
  assign act  = act_q;
endmodule

// File: rtl/idist_regfile.sv
module idist_regfile
  import idist_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int TYPE_N  = 1,
  parameter int ADDR_W  = 12,
  localparam int NSPI   = NUM_SRC - PRIV_N,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [31:0]                     wdata,
  input  logic [CPU_W-1:0]                acc_cpu,
  output logic [31:0]                     rdata,
  output logic                            glb_en,
  output logic [NUM_CPU-1:0][PRIV_N-1:0]  en_priv,
  output logic [NSPI-1:0]                 en_shr,
  output logic [NUM_SRC-1:0]              edge_cfg,
  output logic [NSPI-1:0][TGT_W-1:0]      tgt,
  output logic                            sgi_fire,
  output logic [3:0]                      sgi_id,
  output logic [TGT_W-1:0]                sgi_map
);
  localparam int EN_WORDS  = (NUM_SRC + 31) / 32;
  localparam int TGT_WORDS = (NUM_SRC + 1) / 2;

  logic [NUM_SRC-1:SGI_N]          trig_r;
  logic [EN_WORDS*32-1:0]          en_rd, trig_rd;
  logic [TGT_WORDS-1:0][31:0]      tgt_rd;
  logic [TGT_W-1:0]                own_mask;
  logic [31:0]                     rd_mux;

  assign edge_cfg = {trig_r, {SGI_N{1'b1}}};
  assign own_mask = TGT_W'(1) << acc_cpu;

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en   <= 1'b0;
      en_priv  <= '0;
      en_shr   <= '0;
      trig_r   <= '0;
      tgt      <= '0;
      sgi_fire <= 1'b0;
      sgi_id   <= '0;
      sgi_map  <= '0;
    end else begin
      sgi_fire <= 1'b0;
      if (wr_en) begin
        if (addr == ADDR_W'(A_CTRL)) glb_en <= wdata[0];
        // banked private enables, word 0
        for (int b = 0; b < PRIV_N; b++) begin
          if (addr == ADDR_W'(A_ENSET) && wdata[b]) en_priv[acc_cpu][b] <= 1'b1;
          if (addr == ADDR_W'(A_ENCLR) && wdata[b]) en_priv[acc_cpu][b] <= 1'b0;
        end
        // shared enables and target masks
        for (int j = 0; j < NSPI; j++) begin
          if (addr == ADDR_W'(A_ENSET + ((j + PRIV_N) / 32) * 4) && wdata[(j + PRIV_N) % 32])
            en_shr[j] <= 1'b1;
          if (addr == ADDR_W'(A_ENCLR + ((j + PRIV_N) / 32) * 4) && wdata[(j + PRIV_N) % 32])
            en_shr[j] <= 1'b0;
          if (addr == ADDR_W'(A_TGT + ((j + PRIV_N) / 2) * 4))
            tgt[j] <= ((j + PRIV_N) % 2 == 1) ? wdata[31:16] : wdata[15:0];
        end
        // trigger bits, software sources fixed
        for (int s = SGI_N; s < NUM_SRC; s++) begin
          if (addr == ADDR_W'(A_TRIG + (s / 32) * 4)) trig_r[s] <= wdata[s % 32];
        end
        if (addr == ADDR_W'(A_SWINT)) begin
          sgi_fire <= 1'b1;
          sgi_id   <= wdata[3:0];
          sgi_map  <= wdata[8 +: TGT_W];
        end
      end
    end
  end

  always_comb begin
    en_rd   = '0;
    trig_rd = '0;
    tgt_rd  = '0;
    en_rd[PRIV_N-1:0]    = en_priv[acc_cpu];
    trig_rd[NUM_SRC-1:0] = edge_cfg;
    for (int j = 0; j < NSPI; j++) begin
      en_rd[PRIV_N + j] = en_shr[j];
      tgt_rd[(j + PRIV_N) / 2][((j + PRIV_N) % 2) * TGT_W +: TGT_W] = tgt[j];
    end
    for (int t = 0; t < PRIV_N / 2; t++) tgt_rd[t] = {own_mask, own_mask};
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_CTRL)) rd_mux = {31'b0, glb_en};
    if (addr == ADDR_W'(A_TYPE)) rd_mux = {27'b0, 5'(TYPE_N)};
    for (int w = 0; w < EN_WORDS; w++) begin
      if (addr == ADDR_W'(A_ENSET + 4 * w) || addr == ADDR_W'(A_ENCLR + 4 * w))
        rd_mux = en_rd[w*32 +: 32];
      if (addr == ADDR_W'(A_TRIG + 4 * w)) rd_mux = trig_rd[w*32 +: 32];
    end
    for (int t = 0; t < TGT_WORDS; t++) begin
      if (addr == ADDR_W'(A_TGT + 4 * t)) rd_mux = tgt_rd[t];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/idist_top.sv
module idist_top
  import idist_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int TYPE_N   = 1,
  parameter int ADDR_W   = 12,
  localparam int NUM_SRC = src_count(TYPE_N),
  localparam int NSPI    = NUM_SRC - PRIV_N,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ID_W    = $clog2(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic [CPU_W-1:0]            bus_cpu,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_CPU*16-1:0]       ppi_lines,
  input  logic [NSPI-1:0]             spi_lines,
  input  logic                        ack_valid,
  input  logic [CPU_W-1:0]            ack_cpu,
  input  logic [ID_W-1:0]             ack_id,
  input  logic                        eoi_valid,
  input  logic [CPU_W-1:0]            eoi_cpu,
  input  logic [ID_W-1:0]             eoi_id,
  output logic [NUM_CPU*NUM_SRC-1:0]  cpu_pend
);
  logic                            glb_en;
  logic [NUM_CPU-1:0][PRIV_N-1:0]  en_priv;
  logic [NSPI-1:0]                 en_shr;
  logic [NUM_SRC-1:0]              edge_cfg;
  logic [NSPI-1:0][TGT_W-1:0]      tgt;
  logic                            sgi_fire;
  logic [3:0]                      sgi_id;
  logic [TGT_W-1:0]                sgi_map;

  logic [NUM_CPU-1:0][PRIV_N-1:0]  ack_p, eoi_p, pend_p, act_p;
  logic [NUM_CPU-1:0][SGI_N-1:0]   sgi_set;
  logic [NSPI-1:0]                 ack_s, eoi_s, pend_s, act_s;
  logic [NUM_CPU*NUM_SRC-1:0]      fwd_n;

  idist_regfile #(
    .NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .TYPE_N(TYPE_N), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .acc_cpu(bus_cpu), .rdata(bus_rdata),
    .glb_en(glb_en), .en_priv(en_priv), .en_shr(en_shr), .edge_cfg(edge_cfg),
    .tgt(tgt), .sgi_fire(sgi_fire), .sgi_id(sgi_id), .sgi_map(sgi_map)
  );

  // decode acknowledge / end strobes into per-bank one-hot vectors
  always_comb begin
    for (int k = 0; k < NUM_CPU; k++) begin
      sgi_set[k] = (sgi_fire && sgi_map[k]) ? (SGI_N'(1) << sgi_id) : '0;
      for (int i = 0; i < PRIV_N; i++) begin
        ack_p[k][i] = ack_valid && ack_cpu == CPU_W'(k) && ack_id == ID_W'(i);
        eoi_p[k][i] = eoi_valid && eoi_cpu == CPU_W'(k) && eoi_id == ID_W'(i);
      end
    end
    for (int j = 0; j < NSPI; j++) begin
      ack_s[j] = ack_valid && ack_id == ID_W'(j + PRIV_N);
      eoi_s[j] = eoi_valid && eoi_id == ID_W'(j + PRIV_N);
    end
  end

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_bank
    idist_src_state #(.N(PRIV_N)) u_priv (
      .clk(clk), .rst(rst),
      .lvl_in({ppi_lines[k*16 +: 16], {SGI_N{1'b0}}}),
      .edge_cfg(edge_cfg[PRIV_N-1:0]),
      .sw_set({{(PRIV_N-SGI_N){1'b0}}, sgi_set[k]}),
      .ack(ack_p[k]), .eoi(eoi_p[k]),
      .pend(pend_p[k]), .act(act_p[k])
    );
  end

  idist_src_state #(.N(NSPI)) u_shared (
    .clk(clk), .rst(rst), .lvl_in(spi_lines), .edge_cfg(edge_cfg[NUM_SRC-1:PRIV_N]),
    .sw_set({NSPI{1'b0}}), .ack(ack_s), .eoi(eoi_s), .pend(pend_s), .act(act_s)
  );

  always_comb begin
    fwd_n = '0;
    for (int k = 0; k < NUM_CPU; k++) begin
      for (int i = 0; i < PRIV_N; i++)
        fwd_n[k*NUM_SRC + i] = glb_en & en_priv[k][i] & pend_p[k][i] & ~act_p[k][i];
      for (int j = 0; j < NSPI; j++)
        fwd_n[k*NUM_SRC + PRIV_N + j] = glb_en & en_shr[j] & pend_s[j] & ~act_s[j] & tgt[j][k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_pend <= '0;
    else     cpu_pend <= fwd_n;
  end
endmodule

// File: rtl/idist_sva.sv
module idist_sva #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  localparam int NSPI   = NUM_SRC - 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        glb_en,
  input logic [NSPI-1:0]             en_shr,
  input logic [NSPI-1:0][15:0]       tgt,
  input logic [NSPI-1:0]             act_s,
  input logic [NSPI-1:0]             pend_s,
  input logic [NSPI-1:0]             ack_s,
  input logic [NUM_SRC-1:0]          edge_cfg,
  input logic [NUM_CPU-1:0][31:0]    pend_p,
  input logic                        sgi_fire,
  input logic [3:0]                  sgi_id,
  input logic [15:0]                 sgi_map,
  input logic [NUM_CPU*NUM_SRC-1:0]  cpu_pend
);
  a_r8_gate_off: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> cpu_pend == '0);

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    // R7 and R11: a software interrupt lands in the targeted bank, even against an ack
    a_r7_sgi_lands: assert property (@(posedge clk) disable iff (rst)
      sgi_fire && sgi_map[k] |=> ((pend_p[k] >> $past(sgi_id)) & 32'd1) != 32'd0);
    for (genvar j = 0; j < NSPI; j++) begin : g_src
      a_r10_blocked: assert property (@(posedge clk) disable iff (rst)
        act_s[j] || !tgt[j][k] || !en_shr[j] |=> !cpu_pend[k*NUM_SRC + 32 + j]);
    end
  end

  for (genvar j = 0; j < NSPI; j++) begin : g_edge
    a_r9_edge_hold: assert property (@(posedge clk) disable iff (rst)
      pend_s[j] && edge_cfg[32 + j] && !ack_s[j] |=> pend_s[j] || !edge_cfg[32 + j]);
  end
endmodule

bind idist_top idist_sva #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) sva_i (
  .clk(clk), .rst(rst), .glb_en(glb_en), .en_shr(en_shr), .tgt(tgt),
  .act_s(act_s), .pend_s(pend_s), .ack_s(ack_s), .edge_cfg(edge_cfg),
  .pend_p(pend_p), .sgi_fire(sgi_fire), .sgi_id(sgi_id), .sgi_map(sgi_map),
  .cpu_pend(cpu_pend)
);

// File: tb/idist_top_tb_top.sv
module idist_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int NS  = 64;
  localparam int NSP = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [1:0]        bus_cpu = '0;
  logic [31:0]       bus_rdata;
  logic [NC*16-1:0]  ppi_lines = '0;
  logic [NSP-1:0]    spi_lines = '0;
  logic              ack_valid = 1'b0, eoi_valid = 1'b0;
  logic [1:0]        ack_cpu = '0, eoi_cpu = '0;
  logic [5:0]        ack_id = '0, eoi_id = '0;
  logic [NC*NS-1:0]  cpu_pend;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0]       tgt_m [NSP];
  logic [NSP-1:0]    en_m = '0;
  logic [31:0]       rv;

  idist_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .ppi_lines(ppi_lines), .spi_lines(spi_lines),
    .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
    .cpu_pend(cpu_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] c);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = c;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] c, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_cpu = c;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(logic [1:0] c, logic [5:0] id);
    @(negedge clk);
    ack_valid = 1'b1; ack_cpu = c; ack_id = id;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic eoi(logic [1:0] c, logic [5:0] id);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_cpu = c; eoi_id = id;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_row(int k, logic [NSP-1:0] lvl, logic g);
    logic [63:0] r = '0;
    for (int j = 0; j < NSP; j++) r[32+j] = g & en_m[j] & lvl[j] & tgt_m[j][k];
    return r;
  endfunction

  function automatic logic pbit(int k, int id);
    return cpu_pend[k*NS + id];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NSP-1:0] lvl;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R8 reset cpu_pend", 64'(|cpu_pend), 64'd0);
    rd(12'h000, 0, rv); chk("R8 reset control", 64'(rv), 64'd0);
    rd(12'h004, 0, rv); chk("R6 type code", 64'(rv[4:0]), 64'd1);

    // trigger configuration
    rd(12'hC00, 0, rv); chk("R5 sgi trig fixed", 64'(rv), 64'h0000FFFF);
    wr(12'hC00, 32'h0, 0);
    rd(12'hC00, 0, rv); chk("R5 sgi trig write ignored", 64'(rv), 64'h0000FFFF);
    wr(12'hC00, 32'hFFFF0000, 0);
    rd(12'hC00, 0, rv); chk("R5 ppi trig writable", 64'(rv), 64'hFFFFFFFF);
    wr(12'hC00, 32'h0, 0);
    d = $urandom;
    wr(12'hC04, d, 0);
    rd(12'hC04, 0, rv); chk("R5 shared trig readback", 64'(rv), 64'(d));
    wr(12'hC04, 32'h0, 0);

    // private target words
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < 16; t++) begin
        rd(12'(12'h800 + 4*t), 2'(c), rv);
        chk("R3 private target read", 64'(rv), 64'({16'(1) << c, 16'(1) << c}));
      end
    wr(12'h800, 32'hDEADBEEF, 0);
    rd(12'h800, 0, rv); chk("R3 private target write ignored", 64'(rv), 64'h00010001);

    // shared target masks
    for (int w = 16; w < 32; w++) begin
      d = $urandom;
      wr(12'(12'h800 + 4*w), d, 0);
      tgt_m[2*w-32] = d[15:0];
      tgt_m[2*w-31] = d[31:16];
    end
    for (int w = 16; w < 32; w++) begin
      rd(12'(12'h800 + 4*w), 2'(w % 4), rv);
      chk("R2 target halves", 64'(rv), 64'({tgt_m[2*w-31], tgt_m[2*w-32]}));
    end

    // enables
    d = $urandom; wr(12'h104, d, 0); en_m |= d;
    rd(12'h104, 0, rv); chk("R1 enable set", 64'(rv), 64'(en_m));
    d = $urandom; wr(12'h184, d, 1); en_m &= ~d;
    rd(12'h184, 2, rv); chk("R1 enable clear", 64'(rv), 64'(en_m));
    wr(12'h104, 32'h0, 0); wr(12'h184, 32'h0, 0);
    rd(12'h104, 3, rv); chk("R1 zero bits no effect", 64'(rv), 64'(en_m));
    d = $urandom | 32'h1; wr(12'h104, d, 0); en_m |= d;
    wr(12'h100, 32'h000000F0, 0);
    rd(12'h100, 1, rv); chk("R4 private enable banked", 64'(rv), 64'd0);
    rd(12'h100, 0, rv); chk("R4 private enable own", 64'(rv), 64'h000000F0);
    wr(12'h180, 32'hFFFFFFFF, 0);

    // forwarding under random levels
    wr(12'h000, 32'h1, 0);
    for (int it = 0; it < 24; it++) begin
      if (it == 12) begin
        d = $urandom; wr(12'h184, d, 0); en_m &= ~d;
      end
      lvl = $urandom;
      spi_lines = lvl;
      settle();
      for (int k = 0; k < NC; k++)
        chk("R10 shared forwarding", cpu_pend[k*NS +: NS], exp_row(k, lvl, 1'b1));
    end
    wr(12'h000, 32'h0, 0);
    settle();
    for (int k = 0; k < NC; k++)
      chk("R8 global gate off", cpu_pend[k*NS +: NS], 64'd0);
    wr(12'h000, 32'h1, 0);
    settle();
    chk("R8 global gate on", cpu_pend[0 +: NS], exp_row(0, lvl, 1'b1));
    spi_lines = '0;

    // software interrupts
    wr(12'h100, 32'h1 << 5, 1);
    wr(12'hF00, (32'h0006 << 8) | 32'hA5, 0);
    settle();
    chk("R7 sgi to cpu1", 64'(pbit(1, 5)), 64'd1);
    chk("R4 sgi cpu2 disabled", 64'(pbit(2, 5)), 64'd0);
    chk("R7 sgi not targeted cpu0", 64'(pbit(0, 5)), 64'd0);
    wr(12'h100, 32'h1 << 5, 2);
    settle();
    chk("R4 sgi cpu2 latched", 64'(pbit(2, 5)), 64'd1);
    ack(1, 5); settle();
    chk("R10 ack hides source", 64'(pbit(1, 5)), 64'd0);
    chk("R4 ack banked", 64'(pbit(2, 5)), 64'd1);
    eoi(1, 5); settle();
    chk("R9 edge cleared by ack", 64'(pbit(1, 5)), 64'd0);

    // same-cycle set and acknowledge
    wr(12'hF00, 32'h0002 << 8 | 32'h5, 0);
    ack_valid = 1'b1; ack_cpu = 1; ack_id = 5;
    @(negedge clk);
    ack_valid = 1'b0;
    settle();
    chk("R11 active after ack", 64'(pbit(1, 5)), 64'd0);
    eoi(1, 5); settle();
    chk("R11 pending survived", 64'(pbit(1, 5)), 64'd1);

    // shared edge and level
    wr(12'hC04, 32'h1 << 8, 0);
    wr(12'h104, 32'h3 << 8, 0); en_m |= 32'h3 << 8;
    wr(12'h850, 32'h00010001, 0); tgt_m[8] = 16'h1; tgt_m[9] = 16'h1;
    @(negedge clk); spi_lines[8] = 1'b1;
    @(negedge clk); spi_lines[8] = 1'b0;
    settle();
    chk("R9 edge latched", 64'(pbit(0, 40)), 64'd1);
    chk("R10 edge not targeted", 64'(pbit(1, 40)), 64'd0);
    ack(0, 40); settle();
    chk("R10 edge acked", 64'(pbit(0, 40)), 64'd0);
    eoi(0, 40); settle();
    chk("R9 edge stays clear", 64'(pbit(0, 40)), 64'd0);
    spi_lines[9] = 1'b1; settle();
    chk("R9 level high", 64'(pbit(0, 41)), 64'd1);
    spi_lines[9] = 1'b0; settle();
    chk("R9 level low", 64'(pbit(0, 41)), 64'd0);

    // private peripheral lines banked
    wr(12'h100, 32'h1 << 16, 0);
    ppi_lines[0] = 1'b1; ppi_lines[16] = 1'b1;
    settle();
    chk("R4 ppi cpu0", 64'(pbit(0, 16)), 64'd1);
    chk("R4 ppi cpu1 disabled", 64'(pbit(1, 16)), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule